// File: doc/BRIEF.md
# Per-Byte Self-Synchronizing Serial Transmitter

This block shifts bytes out on one serial line so that a receiver with a loose clock can lock onto every byte by itself. Before each byte the line carries a two-bit sync preamble. It starts with a high bit that lasts longer than a normal bit, followed by a low bit of normal length. The falling edge between the two preamble bits is the timing reference for the data that follows. The data bits then go out least significant bit first, and each one lasts one bit period.

Bytes arrive through a valid/ready handshake. A byte is taken only when the previous one has left the line completely. The preamble goes out again in front of every byte, even when bytes are streamed back to back, so timing is renewed per byte rather than once per message. A single enable output tells an external line driver when the block owns the wire. The `busy` output marks a byte in flight. Both bit lengths are parameters counted in clock cycles.

Top module: `padsync_tx`

## Requirements
- R1: After reset, `line_out` and `line_oe` are 0, `busy` is 0 and `in_ready` is 1.
- R2: A byte is accepted on a rising edge where `in_valid` and `in_ready` are both 1. From the next cycle, `line_out` is 1 for exactly LONG_CYC cycles. LONG_CYC defaults to 3 × BIT_CYC.
- R3: Right after the long high bit, `line_out` is 0 for exactly BIT_CYC cycles.
- R4: Next, the DATA_W data bits appear on `line_out`, bit 0 first, each held for BIT_CYC cycles.
- R5: In the cycle after the last data bit, the block is idle again: `line_out` is 0, `line_oe` is 0, `busy` is 0 and `in_ready` is 1.
- R6: While a byte is in flight, `in_ready` is 0. Changes on `in_valid` and `in_data` then have no effect on the byte on the line.
- R7: `line_oe` is 1 in every cycle of the preamble and data bits and 0 otherwise, and `line_out` is never 1 while `line_oe` is 0.
- R8: If `in_valid` stays high, the next byte is accepted in the first idle cycle. That byte again starts with the full long-high, normal-low preamble.
- R9: An active-low `rst_n` pulse in the middle of a byte drops `line_out`, `line_oe` and `busy` to 0 at once and abandons the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_data | input | DATA_W | Byte to send |
| in_valid | input | 1 | `in_data` is offered |
| in_ready | output | 1 | Block can accept a byte this cycle |
| line_out | output | 1 | Serial line level |
| line_oe | output | 1 | Line driver enable |
| busy | output | 1 | A byte is being sent |

## Verification
The bench builds the block with BIT_CYC = 4 and LONG_CYC = 12. This keeps the 48-cycle frame short, so every cycle of every frame can be compared against a waveform computed in the bench. With these values the 3:1 stretch of the sync bit is the default ratio. The short bit period also lets back-to-back streaming and a reset in the middle of a data bit fit in a few hundred cycles. Together with the all-zero, all-one and single-bit bytes, this puts every timer reload boundary and the end of the last data bit within reach.

// File: rtl/padsync_pkg.sv
package padsync_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_SYNC_HI = 2'd1,
      ST_SYNC_LO = 2'd2,
      ST_DATA    = 2'd3
   } tx_state_e;

endpackage

// File: rtl/padsync_timer.sv
module padsync_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

   // the count taken on a load is the one seen in the following cycle
   AST_TMR_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (cnt_q == $past(load_val))) else $error("timer load lost"); // R3

   // without a load the counter only ever moves down
   AST_TMR_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
      (!load && !expired) |=> (cnt_q == $past(cnt_q) - 1'b1)) else $error("timer skipped"); // R4

endmodule

// File: rtl/padsync_shift.sv
module padsync_shift #(
   parameter int DATA_W = 8,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              shift,
   input  logic [DATA_W-1:0] load_data,
   output logic              out_bit,
   output logic              last_bit
);

   logic [DATA_W-1:0] sr_q;
   logic [IDX_W-1:0]  left_q;

   generate
      if (DATA_W == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else if (load) sr_q <= load_data;
         end
      end else begin : g_multi
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr_q <= '0;
            else if (load) sr_q <= load_data;
            else if (shift) sr_q <= {1'b0, sr_q[DATA_W-1:1]};
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
      end else if (load) begin
         left_q <= IDX_W'(DATA_W - 1);
      end else if (shift) begin
         left_q <= left_q - 1'b1;
      end
   end

   assign out_bit  = sr_q[0];
   assign last_bit = (left_q == '0);

   // no shift may run past the final data bit
   AST_NO_SHIFT_PAST_END: assert property (@(posedge clk) disable iff (!rst_n)
      shift |-> !last_bit) else $error("shift beyond last bit"); // R4

   AST_NO_LOAD_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      !(load && shift)) else $error("load and shift together"); // R6

endmodule

// File: rtl/padsync_seq.sv
module padsync_seq
   import padsync_pkg::*;
#(
   parameter int CNT_W    = 4,
   parameter int BIT_CYC  = 4,
   parameter int LONG_CYC = 12
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             in_valid,
   input  logic             tmr_expired,
   input  logic             last_bit,
   output tx_state_e        state,
   output logic             tmr_load,
   output logic [CNT_W-1:0] tmr_val,
   output logic             sh_load,
   output logic             sh_shift
);

   localparam logic [CNT_W-1:0] LONG_RELOAD = CNT_W'(LONG_CYC - 1);
   localparam logic [CNT_W-1:0] BIT_RELOAD  = CNT_W'(BIT_CYC - 1);

   tx_state_e state_q, state_d;

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = BIT_RELOAD;
      sh_load  = 1'b0;
      sh_shift = 1'b0;
      unique case (state_q)
         ST_IDLE: begin
            if (in_valid) begin
               state_d  = ST_SYNC_HI;
               tmr_load = 1'b1;
               tmr_val  = LONG_RELOAD;
               sh_load  = 1'b1;
            end
         end
         ST_SYNC_HI: begin
            if (tmr_expired) begin
               state_d  = ST_SYNC_LO;
               tmr_load = 1'b1;
            end
         end
         ST_SYNC_LO: begin
            if (tmr_expired) begin
               state_d  = ST_DATA;
               tmr_load = 1'b1;
            end
         end
         ST_DATA: begin
            if (tmr_expired) begin
               if (last_bit) begin
                  state_d = ST_IDLE;
               end else begin
                  tmr_load = 1'b1;
                  sh_shift = 1'b1;
               end
            end
         end
         default: state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) state_q <= ST_IDLE;
      else        state_q <= state_d;
   end

   assign state = state_q;

   // the stretched high bit always leads into the normal low bit
   AST_HI_THEN_LO: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_SYNC_HI && tmr_expired) |=> (state_q == ST_SYNC_LO)) else $error("sync order"); // R3

   AST_IDLE_ONLY_AFTER_DATA: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q != ST_IDLE && state_d == ST_IDLE) |-> (state_q == ST_DATA && last_bit)) else $error("early idle"); // R5

endmodule

// File: rtl/padsync_tx.sv
module padsync_tx
   import padsync_pkg::*;
#(
   parameter int DATA_W   = 8,
   parameter int BIT_CYC  = 16,
   parameter int LONG_CYC = 3 * BIT_CYC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   output logic              line_out,
   output logic              line_oe,
   output logic              busy
);

   localparam int CNT_W = (LONG_CYC > 2) ? $clog2(LONG_CYC) : 1;
   localparam int IDX_W = (DATA_W > 2) ? $clog2(DATA_W) : 1;

   generate
      if (BIT_CYC < 1) begin : g_bad_bit
         $error("BIT_CYC must be at least 1");
      end
      if (LONG_CYC <= BIT_CYC) begin : g_bad_long
         $error("LONG_CYC must exceed BIT_CYC");
      end
      if (DATA_W < 1) begin : g_bad_width
         $error("DATA_W must be at least 1");
      end
   endgenerate

   tx_state_e        state;
   logic             tmr_load, tmr_expired;
   logic [CNT_W-1:0] tmr_val;
   logic             sh_load, sh_shift, sh_bit, sh_last;

   padsync_seq #(
      .CNT_W    (CNT_W),
      .BIT_CYC  (BIT_CYC),
      .LONG_CYC (LONG_CYC)
   ) u_seq (
      .clk         (clk),
      .rst_n       (rst_n),
      .in_valid    (in_valid),
      .tmr_expired (tmr_expired),
      .last_bit    (sh_last),
      .state       (state),
      .tmr_load    (tmr_load),
      .tmr_val     (tmr_val),
      .sh_load     (sh_load),
      .sh_shift    (sh_shift)
   );

   padsync_timer #(
      .CNT_W (CNT_W)
   ) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   padsync_shift #(
      .DATA_W (DATA_W),
      .IDX_W  (IDX_W)
   ) u_shift (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (sh_load),
      .shift     (sh_shift),
      .load_data (in_data),
      .out_bit   (sh_bit),
      .last_bit  (sh_last)
   );

   assign busy     = (state != ST_IDLE);
   assign in_ready = !busy;
   assign line_oe  = busy;
   assign line_out = (state == ST_SYNC_HI) || ((state == ST_DATA) && sh_bit);

   // a handshake starts the stretched high bit on the very next cycle
   AST_PAD_START: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready) |=> (line_out && line_oe)) else $error("no sync high"); // R2

   AST_NO_ACCEPT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !in_ready) else $error("ready while busy"); // R6

   AST_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      !line_oe |-> !line_out) else $error("undriven high"); // R7

   AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_DATA && !tmr_expired) |=> $stable(line_out)) else $error("bit glitch"); // R4

   AST_SYNC_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SYNC_HI && tmr_expired) |=> (!line_out && line_oe)) else $error("no sync low"); // R3

endmodule

// File: tb/sim_padsync_tx.sv
module sim_padsync_tx;

   localparam int CLK_PERIOD = 10;
   localparam int DW   = 8;
   localparam int BITC = 4;
   localparam int LONG = 12;
   localparam int FRAME = LONG + BITC + DW * BITC;

   // each entry: byte to send, expected number of high cycles in its frame
   localparam logic [15:0] VEC [0:7] = '{
      {8'h00, 8'd12}, {8'hFF, 8'd44}, {8'h01, 8'd16}, {8'h80, 8'd16},
      {8'hA5, 8'd28}, {8'h5A, 8'd28}, {8'h3C, 8'd28}, {8'h7E, 8'd36}
   };

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [DW-1:0] in_data = '0;
   logic in_valid = 1'b0;
   logic in_ready, line_out, line_oe, busy;

   int checks = 0;
   int errors = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   padsync_tx #(.DATA_W(DW), .BIT_CYC(BITC), .LONG_CYC(LONG)) u0 (
      .clk(clk), .rst_n(rst_n), .in_data(in_data), .in_valid(in_valid),
      .in_ready(in_ready), .line_out(line_out), .line_oe(line_oe), .busy(busy)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   function automatic logic exp_level(input logic [DW-1:0] b, input int i);
      int j;
      if (i < LONG) return 1'b1;
      j = i - LONG;
      if (j < BITC) return 1'b0;
      return b[(j - BITC) / BITC];
   endfunction

   // called right after the accepting edge; samples every frame cycle at negedge
   task automatic frame_check(input logic [DW-1:0] b, input int exp_high,
                              input bit keep_valid, input logic [DW-1:0] next_b);
      int bad = 0, highs = 0, oe_bad = 0, rdy_bad = 0, first_bad = -1;
      for (int i = 0; i < FRAME; i++) begin
         @(negedge clk);
         if (line_out !== exp_level(b, i)) begin
            bad++;
            if (first_bad < 0) first_bad = i;
         end
         if (line_out === 1'b1) highs++;
         if (line_oe !== 1'b1 || busy !== 1'b1) oe_bad++;
         if (in_ready !== 1'b0) rdy_bad++;
         if (i == 0) begin
            in_data  = keep_valid ? next_b : ~b;   // R6: changes while busy
            in_valid = keep_valid;
         end
         if (i == 5 && !keep_valid) in_valid = 1'b1;  // R6: offered while busy
         if (i == 6 && !keep_valid) in_valid = 1'b0;
      end
      check(bad == 0, "R2 R3 R4 frame waveform (first bad cycle shown)", first_bad, -1);
      check(highs == exp_high, "R4 high cycle count", highs, exp_high);
      check(oe_bad == 0, "R7 oe and busy during frame", oe_bad, 0);
      check(rdy_bad == 0, "R6 ready low while busy", rdy_bad, 0);
   endtask

   task automatic idle_check(input string req);
      check(line_out === 1'b0, req, int'(line_out), 0);
      check(line_oe === 1'b0 && busy === 1'b0, req, int'({line_oe, busy}), 0);
      check(in_ready === 1'b1, req, int'(in_ready), 1);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      idle_check("R1 reset state");
      rst_n = 1'b1;
      @(negedge clk);
      idle_check("R1 after reset release");

      // table walk: single bytes with gaps
      for (int v = 0; v < 8; v++) begin
         @(negedge clk);
         in_data  = VEC[v][15:8];
         in_valid = 1'b1;
         @(posedge clk);
         frame_check(VEC[v][15:8], int'(VEC[v][7:0]), 1'b0, '0);
         @(negedge clk);
         idle_check("R5 idle after last bit");
      end

      // R8: streaming with valid held high
      @(negedge clk);
      in_data  = 8'hC3;
      in_valid = 1'b1;
      @(posedge clk);
      frame_check(8'hC3, LONG + 4 * BITC, 1'b1, 8'h81);
      @(negedge clk);
      check(in_ready === 1'b1 && line_oe === 1'b0, "R8 single idle gap", int'(in_ready), 1);
      @(posedge clk);
      frame_check(8'h81, LONG + 2 * BITC, 1'b0, '0);
      @(negedge clk);
      idle_check("R8 R5 idle after streamed byte");

      // R9: reset in the middle of a data bit
      @(negedge clk);
      in_data  = 8'hFF;
      in_valid = 1'b1;
      @(posedge clk);
      @(negedge clk);
      in_valid = 1'b0;
      repeat (LONG + BITC + 2) @(negedge clk);
      check(line_out === 1'b1, "R9 precondition data high", int'(line_out), 1);
      rst_n = 1'b0;
      #1;
      idle_check("R9 reset mid byte");
      @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      idle_check("R9 stays idle after reset");

      // after abort, a fresh byte still goes out whole
      in_data  = 8'h01;
      in_valid = 1'b1;
      @(posedge clk);
      frame_check(8'h01, LONG + BITC, 1'b0, '0);
      @(negedge clk);
      idle_check("R5 idle after recovery byte");

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule